// File: doc/BRIEF.md
# Character Display Instruction Decoder

This block is the controller side of a character display module. A host drives a small parallel bus made of a register-select line, a direction line, an enable strobe and an 8-bit data bus. Each transfer completes when the enable strobe falls. Depending on the select and direction lines, a transfer is one of four kinds: an instruction write, a status read, a data write or a data read.

Instruction writes are decoded by their most significant set bit. They change the mode state, load or reset the address counter, clear the display memory, or move the cursor or the visible window. A single address counter serves both memories, the display character store and the glyph pattern store. The most recent set-address instruction decides which memory the counter points into. After every accepted data access the counter steps up or down, as the entry mode selects. It wraps in the way each memory and line mode requires.

Every accepted operation holds a busy flag for a programmable number of clock cycles. Clear and home use the long time, and everything else uses the short time. A status read returns the busy flag and the counter at any time. Any other transfer that arrives while the block is busy is dropped and recorded in a sticky overrun flag.

Top module: `chlcd_ctrl`

## Requirements
- R1: A transfer takes effect in the clock cycle after the enable input is seen falling. An instruction write is decoded by its highest set data bit, and that bit alone selects the instruction. Bit 7 loads the display address, bit 6 loads the pattern address, bit 5 is function set, bit 4 is move/shift, bit 3 is display control, bit 2 is entry mode, bit 1 is home, and value 01h is clear.
- R2: Clear writes 20h to every display-store byte, puts the counter at display address 0 and zeroes the window offset.
- R3: Home puts the counter at display address 0 and zeroes the window offset. It leaves the memory contents untouched.
- R4: Display control stores data bit 2 as display on, bit 1 as cursor on and bit 0 as blink. Function set stores data bit 4 as 8-bit bus, bit 3 as two-line and bit 2 as tall font. Entry mode stores data bit 1 as step-up and bit 0 as shift-with-access. All of these appear on output ports.
- R5: A set-pattern-address instruction (40h to 7Fh) loads the counter with data bits 5..0 and points it at the pattern store. A set-display-address instruction (bit 7 set) loads the counter with data bits 6..0 and points it at the display store.
- R6: A data write stores the byte at the counter in the selected store. A data read presents that byte on the output bus while enable is high. Each accepted data access then steps the counter up when step-up is 1 and down when it is 0.
- R7: In two-line mode the display counter steps 27h to 40h and 67h to 00h going up, and the reverse going down. In one-line mode it steps 4Fh to 00h going up and 00h to 4Fh going down.
- R8: The pattern counter wraps modulo 64 in both directions.
- R9: A status read (select=0, direction=1) returns the busy flag on bit 7 and the counter on bits 6..0. It has no side effect and is always served.
- R10: Clear and home hold busy for LONG_CYC cycles. Every other accepted instruction, and every data access, holds it for SHORT_CYC cycles. A non-status transfer that arrives while busy is ignored and sets the overrun flag, which stays set until reset.
- R11: Move/shift uses data bit 3 to pick window (1) or cursor (0), and data bit 2 to pick right (1) or left (0). A cursor move steps the counter up for right and down for left, with the R7 wraps. A left window shift raises the offset by one and a right window shift lowers it by one, modulo 40 in two-line mode and modulo 80 in one-line mode.
- R12: When shift-with-access is set, each accepted access to the display store also moves the window offset by one. The offset goes up when step-up is 1 and down when it is 0. Accesses to the pattern store leave the offset alone.
- R13: After reset the counter is display address 0, busy and overrun are clear, step-up is 1 and shift-with-access is 0. Display, cursor, blink, two-line and tall are 0, and 8-bit bus is 1. The offset is 0, the display store holds 20h and the pattern store holds 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_data | input | 1 | 1 selects the data register, 0 selects instruction/status |
| dir_rd | input | 1 | 1 for a read transfer, 0 for a write transfer |
| xfer_en | input | 1 | Transfer strobe; the transfer completes on its falling edge |
| bus_din | input | 8 | Write data from the host |
| bus_dout | output | 8 | Read data: status word or store byte, 0 when not reading |
| disp_on | output | 1 | Display enable flag |
| cursor_on | output | 1 | Cursor visible flag |
| blink_on | output | 1 | Cursor blink flag |
| bus_8bit | output | 1 | Interface width flag |
| two_line | output | 1 | Two-line mode flag |
| font_tall | output | 1 | Tall glyph flag |
| shift_ofs | output | 7 | Current window offset |
| overrun | output | 1 | Sticky flag for a transfer dropped while busy |

## Verification
The bench goes after the counter seams: 27h/40h and 67h/00h in two-line mode, 4Fh/00h in one-line mode, and the 3Fh/00h pattern wrap, in both directions. A design that got a seam wrong would show an address such as 28h or 68h in the status word. It checks that the highest set bit selects the instruction (3Fh must act as function set with all flags on); a decoder keyed to the low bits would run the wrong instruction. It polls status while the long busy time of home is still running and fires an instruction into it. A design that measured the wrong time, or obeyed the dropped instruction, would show busy clear too early, changed display flags or no overrun. It also checks that clear blanks the memory while home keeps it, and that the window offset wraps at 79 in one-line mode.

// File: rtl/chlcd_pkg.sv
package chlcd_pkg;

    localparam int          DD_AW   = 7;
    localparam int          CG_AW   = 6;
    localparam logic [7:0]  BLANK   = 8'h20;
    localparam logic [6:0]  SPAN_2L = 7'd40;
    localparam logic [6:0]  SPAN_1L = 7'd80;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CLEAR,
        OP_HOME,
        OP_ENTRY,
        OP_DISP,
        OP_SHIFT,
        OP_FUNC,
        OP_CGADR,
        OP_DDADR
    } op_e;

    typedef struct packed {
        logic inc;
        logic shf;
    } entry_t;

    typedef struct packed {
        logic on;
        logic cur;
        logic blink;
    } disp_t;

    typedef struct packed {
        logic bus8;
        logic two;
        logic tall;
    } func_t;

    // Highest set bit picks the instruction.
    function automatic op_e decode_op(input logic [7:0] d);
        op_e r;
        casez (d)
            8'b1???????: r = OP_DDADR;
            8'b01??????: r = OP_CGADR;
            8'b001?????: r = OP_FUNC;
            8'b0001????: r = OP_SHIFT;
            8'b00001???: r = OP_DISP;
            8'b000001??: r = OP_ENTRY;
            8'b0000001?: r = OP_HOME;
            8'b00000001: r = OP_CLEAR;
            default:     r = OP_NONE;
        endcase
        return r;
    endfunction

    // Display-store counter step with per-line seams.
    function automatic logic [6:0] dd_step(input logic [6:0] a, input logic up,
                                           input logic two);
        logic [6:0] r;
        if (two) begin
            if (up) r = (a == 7'h27) ? 7'h40 : (a == 7'h67) ? 7'h00 : a + 7'd1;
            else    r = (a == 7'h40) ? 7'h27 : (a == 7'h00) ? 7'h67 : a - 7'd1;
        end else begin
            if (up) r = (a == 7'h4F) ? 7'h00 : a + 7'd1;
            else    r = (a == 7'h00) ? 7'h4F : a - 7'd1;
        end
        return r;
    endfunction

    // Pattern-store counter step, modulo 64.
    function automatic logic [6:0] cg_step(input logic [5:0] a, input logic up);
        logic [5:0] r;
        r = up ? a + 6'd1 : a - 6'd1;
        return {1'b0, r};
    endfunction

    // Window offset step, modulo the line span.
    function automatic logic [6:0] shift_step(input logic [6:0] s, input logic up,
                                              input logic two);
        logic [6:0] span;
        logic [6:0] r;
        span = two ? SPAN_2L : SPAN_1L;
        if (up) r = (s >= span - 7'd1) ? 7'd0 : s + 7'd1;
        else    r = (s == 7'd0 || s >= span) ? span - 7'd1 : s - 7'd1;
        return r;
    endfunction

endpackage

// File: rtl/chlcd_busy.sv
module chlcd_busy #(
    parameter int LONG_CYC  = 82000,
    parameter int SHORT_CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic long_sel,
    output logic busy
);
    localparam int CW = $clog2(LONG_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= long_sel ? CW'(LONG_CYC) : CW'(SHORT_CYC);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R10

endmodule

// File: rtl/chlcd_ram.sv
module chlcd_ram #(
    parameter int         AW   = 7,
    parameter logic [7:0] FILL = 8'h00
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= FILL;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/chlcd_addr.sv
module chlcd_addr
    import chlcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       home,
    input  logic       load,
    input  logic       load_cg,
    input  logic [6:0] load_val,
    input  logic       step,
    input  logic       step_up,
    input  logic       two_line,
    output logic [6:0] ac,
    output logic       is_cg
);

    always_ff @(posedge clk) begin
        if (rst || home) begin
            ac    <= 7'd0;
            is_cg <= 1'b0;
        end else if (load) begin
            ac    <= load_val;
            is_cg <= load_cg;
        end else if (step) begin
            ac <= is_cg ? cg_step(ac[5:0], step_up) : dd_step(ac, step_up, two_line);
        end
    end

    AST_DD_SEAM_UP: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !home && step_up && !is_cg && two_line && ac == 7'h27)
        |=> ac == 7'h40); // R7

    AST_DD_SEAM_DOWN: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !home && !step_up && !is_cg && two_line && ac == 7'h00)
        |=> ac == 7'h67); // R7

    AST_CG_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !home && step_up && is_cg && ac[5:0] == 6'h3F)
        |=> ac == 7'h00); // R8

endmodule

// File: rtl/chlcd_ctrl.sv
module chlcd_ctrl
    import chlcd_pkg::*;
#(
    parameter int LONG_CYC  = 82000,
    parameter int SHORT_CYC = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_data,
    input  logic       dir_rd,
    input  logic       xfer_en,
    input  logic [7:0] bus_din,
    output logic [7:0] bus_dout,
    output logic       disp_on,
    output logic       cursor_on,
    output logic       blink_on,
    output logic       bus_8bit,
    output logic       two_line,
    output logic       font_tall,
    output logic [6:0] shift_ofs,
    output logic       overrun
);

    logic       en_q;
    logic       fall, status_rd, touch, accept, reject;
    logic       do_instr, do_data, do_dwr;
    logic       busy, busy_start, long_sel;
    logic       go_home, load, load_cg, cur_move, step, step_up;
    logic [6:0] load_val;
    logic [6:0] ac;
    logic       is_cg;
    logic [7:0] dd_q, cg_q;
    op_e        op;
    entry_t     ent_q;
    disp_t      disp_q;
    func_t      func_q;
    logic [6:0] sh_q;
    logic       ovr_q;

    // Transfer strobe: completes on the falling enable edge.
    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= xfer_en;
    end

    assign fall      = en_q & ~xfer_en;
    assign status_rd = fall & ~sel_data & dir_rd;
    assign touch     = fall & ~status_rd;
    assign accept    = touch & ~busy;
    assign reject    = touch & busy;
    assign do_instr  = accept & ~sel_data & ~dir_rd;
    assign do_data   = accept & sel_data;
    assign do_dwr    = do_data & ~dir_rd;

    assign op        = decode_op(bus_din);
    assign go_home   = do_instr && (op == OP_CLEAR || op == OP_HOME);
    assign load      = do_instr && (op == OP_CGADR || op == OP_DDADR);
    assign load_cg   = (op == OP_CGADR);
    assign load_val  = load_cg ? {1'b0, bus_din[5:0]} : bus_din[6:0];
    assign cur_move  = do_instr && (op == OP_SHIFT) && !bus_din[3];
    assign step      = do_data | cur_move;
    assign step_up   = do_data ? ent_q.inc : bus_din[2];
    assign busy_start = do_data || (do_instr && op != OP_NONE);
    assign long_sel  = (op == OP_CLEAR || op == OP_HOME);

    chlcd_busy #(
        .LONG_CYC (LONG_CYC),
        .SHORT_CYC(SHORT_CYC)
    ) u_busy (
        .clk     (clk),
        .rst     (rst),
        .start   (busy_start),
        .long_sel(long_sel),
        .busy    (busy)
    );

    chlcd_addr u_addr (
        .clk     (clk),
        .rst     (rst),
        .home    (go_home),
        .load    (load),
        .load_cg (load_cg),
        .load_val(load_val),
        .step    (step),
        .step_up (step_up),
        .two_line(func_q.two),
        .ac      (ac),
        .is_cg   (is_cg)
    );

    chlcd_ram #(.AW(DD_AW), .FILL(BLANK)) u_dd (
        .clk  (clk),
        .rst  (rst),
        .clr  (do_instr && op == OP_CLEAR),
        .we   (do_dwr && !is_cg),
        .waddr(ac),
        .wdata(bus_din),
        .raddr(ac),
        .rdata(dd_q)
    );

    chlcd_ram #(.AW(CG_AW), .FILL(8'h00)) u_cg (
        .clk  (clk),
        .rst  (rst),
        .clr  (1'b0),
        .we   (do_dwr && is_cg),
        .waddr(ac[5:0]),
        .wdata(bus_din),
        .raddr(ac[5:0]),
        .rdata(cg_q)
    );

    // Mode state, window offset and overrun.
    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q  <= '{inc: 1'b1, shf: 1'b0};
            disp_q <= '{on: 1'b0, cur: 1'b0, blink: 1'b0};
            func_q <= '{bus8: 1'b1, two: 1'b0, tall: 1'b0};
            sh_q   <= 7'd0;
            ovr_q  <= 1'b0;
        end else begin
            if (reject) ovr_q <= 1'b1;
            if (do_instr) begin
                case (op)
                    OP_ENTRY: ent_q  <= '{inc: bus_din[1], shf: bus_din[0]};
                    OP_DISP:  disp_q <= '{on: bus_din[2], cur: bus_din[1], blink: bus_din[0]};
                    OP_FUNC:  func_q <= '{bus8: bus_din[4], two: bus_din[3], tall: bus_din[2]};
                    OP_CLEAR,
                    OP_HOME:  sh_q   <= 7'd0;
                    OP_SHIFT: if (bus_din[3]) sh_q <= shift_step(sh_q, ~bus_din[2], func_q.two);
                    default: ;
                endcase
            end
            if (do_data && ent_q.shf && !is_cg)
                sh_q <= shift_step(sh_q, ent_q.inc, func_q.two);
        end
    end

    always_comb begin
        bus_dout = 8'h00;
        if (dir_rd) bus_dout = sel_data ? (is_cg ? cg_q : dd_q) : {busy, ac};
    end

    assign disp_on   = disp_q.on;
    assign cursor_on = disp_q.cur;
    assign blink_on  = disp_q.blink;
    assign bus_8bit  = func_q.bus8;
    assign two_line  = func_q.two;
    assign font_tall = func_q.tall;
    assign shift_ofs = sh_q;
    assign overrun   = ovr_q;

    AST_REJECT_HOLDS_AC: assert property (@(posedge clk) disable iff (rst)
        reject |=> (ac == $past(ac) && is_cg == $past(is_cg))); // R10

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovr_q |=> ovr_q); // R10

    AST_CLEAR_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        (do_instr && op == OP_CLEAR) |=> (ac == 7'd0 && !is_cg && sh_q == 7'd0)); // R2

    AST_STATUS_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        status_rd |=> (ac == $past(ac) && ovr_q == $past(ovr_q))); // R9

endmodule

// File: tb/tb_chlcd_ctrl.sv
module tb_chlcd_ctrl;

    localparam int LONG  = 40;
    localparam int SHORT = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_data = 1'b0, dir_rd = 1'b0, xfer_en = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;
    logic       disp_on, cursor_on, blink_on, bus_8bit, two_line, font_tall, overrun;
    logic [6:0] shift_ofs;

    chlcd_ctrl #(.LONG_CYC(LONG), .SHORT_CYC(SHORT)) dut (
        .clk(clk), .rst(rst), .sel_data(sel_data), .dir_rd(dir_rd), .xfer_en(xfer_en),
        .bus_din(bus_din), .bus_dout(bus_dout), .disp_on(disp_on), .cursor_on(cursor_on),
        .blink_on(blink_on), .bus_8bit(bus_8bit), .two_line(two_line), .font_tall(font_tall),
        .shift_ofs(shift_ofs), .overrun(overrun)
    );

    always #2 clk = ~clk;

    // Reference model state
    int         m_ac = 0;
    bit         m_cg = 0;
    bit         m_inc = 1, m_shf = 0;
    bit         m_d = 0, m_c = 0, m_b = 0;
    bit         m_dl = 1, m_n = 0, m_f = 0;
    int         m_sh = 0;
    bit         m_ovr = 0;
    int         m_busy = 0;
    logic [7:0] m_dd [128];
    logic [7:0] m_cgm [64];

    int  n_cmp = 0, n_bad = 0, cyc = 0;
    bit  live = 0;
    logic [7:0] got;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (m_busy > 0) m_busy = m_busy - 1;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    // Per-clock comparison of the mode outputs (R4, R10, R11, R12)
    always @(negedge clk) begin
        if (live) begin
            chk("R4 display flags", {disp_on, cursor_on, blink_on}, {m_d, m_c, m_b});
            chk("R4 function flags", {bus_8bit, two_line, font_tall}, {m_dl, m_n, m_f});
            chk("R11 window offset", shift_ofs, m_sh);
            chk("R10 overrun flag", overrun, m_ovr);
        end
    end

    function automatic int dd_next(int a, bit up, bit two);
        if (two) begin
            if (up) return (a == 'h27) ? 'h40 : (a == 'h67) ? 0 : a + 1;
            return (a == 'h40) ? 'h27 : (a == 0) ? 'h67 : a - 1;
        end
        if (up) return (a == 'h4F) ? 0 : (a + 1) % 128;
        return (a == 0) ? 'h4F : a - 1;
    endfunction

    function automatic int sh_next(int s, bit up, bit two);
        int span = two ? 40 : 80;
        if (up) return (s + 1) % span;
        return (s + span - 1) % span;
    endfunction

    task automatic advance(input bit up);
        if (m_cg) m_ac = (m_ac + (up ? 1 : 63)) % 64;
        else      m_ac = dd_next(m_ac, up, m_n);
    endtask

    task automatic model_apply(input bit s, input bit r, input logic [7:0] d, input bit was_busy);
        if (!s && r) return;
        if (was_busy) begin m_ovr = 1; return; end
        if (s) begin
            if (!r) begin
                if (m_cg) m_cgm[m_ac % 64] = d; else m_dd[m_ac] = d;
            end
            if (!m_cg && m_shf) m_sh = sh_next(m_sh, m_inc, m_n);
            advance(m_inc);
            m_busy = SHORT;
            return;
        end
        if (d >= 128)     begin m_cg = 0; m_ac = d - 128; end
        else if (d >= 64) begin m_cg = 1; m_ac = d - 64; end
        else if (d >= 32) begin m_dl = d[4]; m_n = d[3]; m_f = d[2]; end
        else if (d >= 16) begin
            if (d[3]) m_sh = sh_next(m_sh, !d[2], m_n);
            else      advance(d[2]);
        end
        else if (d >= 8)  begin m_d = d[2]; m_c = d[1]; m_b = d[0]; end
        else if (d >= 4)  begin m_inc = d[1]; m_shf = d[0]; end
        else if (d >= 2)  begin m_ac = 0; m_cg = 0; m_sh = 0; end
        else if (d == 1)  begin
            for (int i = 0; i < 128; i++) m_dd[i] = 8'h20;
            m_ac = 0; m_cg = 0; m_sh = 0;
        end
        else return;
        m_busy = (d == 1 || d == 2 || d == 3) ? LONG : SHORT;
    endtask

    // One bus transfer; read data compared while enable is high.
    task automatic xfer(input bit s, input bit r, input logic [7:0] d, input string tag,
                        output logic [7:0] rd);
        bit         wb;
        logic [7:0] exp;
        @(negedge clk);
        sel_data = s; dir_rd = r; bus_din = d; xfer_en = 1'b1;
        @(negedge clk);
        rd = bus_dout;
        wb = (m_busy > 0);
        if (r) begin
            if (!s)        exp = {wb, 7'(m_ac)};
            else if (m_cg) exp = m_cgm[m_ac % 64];
            else           exp = m_dd[m_ac];
            chk(tag, rd, exp);
        end
        xfer_en = 1'b0;
        @(posedge clk);
        #1;
        model_apply(s, r, d, wb);
    endtask

    task automatic wait_idle();
        logic [7:0] st;
        for (int k = 0; k < 200; k++) begin
            xfer(1'b0, 1'b1, 8'h00, "R9 status poll", st);
            if (!st[7]) return;
        end
    endtask

    task automatic cmd(input logic [7:0] d);
        logic [7:0] x;
        wait_idle();
        xfer(1'b0, 1'b0, d, "R1 instruction", x);
    endtask

    task automatic dwr(input logic [7:0] d);
        logic [7:0] x;
        wait_idle();
        xfer(1'b1, 1'b0, d, "R6 data write", x);
    endtask

    task automatic drd(input string tag, output logic [7:0] v);
        wait_idle();
        xfer(1'b1, 1'b1, 8'h00, tag, v);
    endtask

    task automatic stat(input string tag, output logic [7:0] v);
        wait_idle();
        xfer(1'b0, 1'b1, 8'h00, tag, v);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) m_dd[i] = 8'h20;
        for (int i = 0; i < 64; i++) m_cgm[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        live = 1;

        // R13 reset state
        xfer(1'b0, 1'b1, 8'h00, "R13 reset status", got);
        chk("R13 reset status word", got, 8'h00);
        chk("R13 reset flags", {disp_on, cursor_on, blink_on, bus_8bit, two_line, font_tall},
            6'b000100);
        drd("R13 blank display byte", got);
        chk("R13 display store holds blanks", got, 8'h20);

        // R1 highest set bit selects function set
        cmd(8'h3F);
        chk("R1 priority 3Fh is function set", {bus_8bit, two_line, font_tall}, 3'b111);
        cmd(8'h38);
        cmd(8'h06);
        cmd(8'h0F);
        chk("R4 display control 0Fh", {disp_on, cursor_on, blink_on}, 3'b111);

        // R5, R6, R7 two-line seam going up
        cmd(8'hA6);
        dwr("A"); dwr("B"); dwr("C");
        stat("R7 status after seam", got);
        chk("R7 27h steps to 40h", got, 8'h41);
        cmd(8'hA6);
        drd("R6 read back", got); chk("R6 byte at 26h", got, "A");
        drd("R6 read back", got); chk("R6 byte at 27h", got, "B");
        drd("R6 read back", got); chk("R6 byte at 40h", got, "C");
        cmd(8'hE7);
        dwr("D");
        stat("R7 status", got);
        chk("R7 67h steps to 00h", got, 8'h00);

        // R7 seams going down
        cmd(8'h04);
        dwr("E");
        stat("R7 status", got);
        chk("R7 00h steps down to 67h", got, 8'h67);
        cmd(8'hC0);
        dwr("F");
        stat("R7 status", got);
        chk("R7 40h steps down to 27h", got, 8'h27);

        // R5, R8 pattern store
        cmd(8'h7F);
        cmd(8'h06);
        dwr(8'h1F);
        stat("R8 status", got);
        chk("R8 pattern 3Fh wraps to 00h", got, 8'h00);
        cmd(8'h04);
        dwr(8'h11);
        stat("R8 status", got);
        chk("R8 pattern 00h wraps down to 3Fh", got, 8'h3F);
        cmd(8'h7F);
        drd("R5 pattern read", got);
        chk("R5 pattern byte at 3Fh", got, 8'h1F);

        // R7 one-line seam
        cmd(8'h30);
        cmd(8'h06);
        cmd(8'hCF);
        dwr("G");
        stat("R7 status", got);
        chk("R7 one-line 4Fh wraps to 00h", got, 8'h00);

        // R11 cursor move and window shift
        cmd(8'h14);
        stat("R11 status", got);
        chk("R11 cursor right", got, 8'h01);
        cmd(8'h10);
        stat("R11 status", got);
        chk("R11 cursor left", got, 8'h00);
        cmd(8'h1C);
        chk("R11 window right wraps to 79", shift_ofs, 7'd79);
        cmd(8'h18);
        chk("R11 window left back to 0", shift_ofs, 7'd0);

        // R12 shift with access
        cmd(8'h07);
        dwr("H"); dwr("I");
        chk("R12 offset after two writes", shift_ofs, 7'd2);

        // R10 short busy right after a data write
        xfer(1'b0, 1'b1, 8'h00, "R10 status", got);
        chk("R10 busy after data write", got[7], 1'b1);

        // R3 home, long busy, overrun
        cmd(8'h02);
        chk("R3 offset zeroed", shift_ofs, 7'd0);
        repeat (SHORT + 4) @(negedge clk);
        xfer(1'b0, 1'b1, 8'h00, "R3 status", got);
        chk("R3 long busy still set", got, 8'h80);
        xfer(1'b0, 1'b0, 8'h08, "R10 dropped instruction", got);
        chk("R10 dropped display control", {disp_on, cursor_on, blink_on}, 3'b111);
        chk("R10 overrun set", overrun, 1'b1);
        drd("R3 memory kept", got);
        chk("R3 byte at 00h kept", got, "H");

        // R2 clear
        cmd(8'h01);
        stat("R2 status", got);
        chk("R2 counter at origin", got, 8'h00);
        chk("R10 overrun still set", overrun, 1'b1);
        drd("R2 blank", got);
        chk("R2 byte 00h blank", got, 8'h20);
        cmd(8'hA6);
        drd("R2 blank", got);
        chk("R2 byte 26h blank", got, 8'h20);

        wait_idle();
        live = 0;
        finish_run();
    end

endmodule